// File: doc/BRIEF.md
# I2C Byte Acknowledge and Status Controller

This block runs the acknowledge clock of an I2C byte engine. An external bit-level shifter tells it when SCL rises or falls (single-cycle strobes) and which bit of the byte is in progress. Bits 0 to 7 are data and bit 8 is the acknowledge clock. When the engine receives a byte, the block picks the acknowledge level, registers it and asks the pad to pull SDA low for an ACK. When the engine transmits a byte, the block samples the receiver's answer and keeps it as status. It also raises a flag for as long as the bus is inside an acknowledge window.

The level driven comes from one of two programmable values. A remaining-byte counter chooses between them: one value applies once the count has run out, the other applies while bytes remain or when the byte is a matching address. The block also holds the host Stop request bit, which only hardware clears. It keeps two sticky client-mode error flags, receive overflow and transmit underflow, that software clears. Start/Stop waveforms, address comparison and clock stretching happen elsewhere and arrive here as inputs.

Top module: `i2c_ack_status`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), every output is 0: sda_low, ack_time, ack_stat, byte_cnt, stop_pend, rx_ovf, tx_unf.
- R2: In the receive direction (dir_tx=0), with byte_cnt equal to 0 and addr_hit=0, the acknowledge level is ack_eoc (1 = NACK, 0 = ACK). The block shows an ACK by setting sda_low=1 for the slot and a NACK by leaving it at 0.
- R3: In the receive direction, with byte_cnt nonzero or addr_hit=1, the acknowledge level is ack_data (1 = NACK, 0 = ACK). It appears on sda_low in the same way as in R2.
- R4: The acknowledge level is registered on the SCL falling strobe with bit_idx=7. sda_low can be 1 only from that cycle until the SCL falling strobe with bit_idx=8. During that window the level does not follow later changes on ack_data, ack_eoc, addr_hit or byte_cnt.
- R5: In the transmit direction (dir_tx=1), the SCL rising strobe with bit_idx=8 latches sda_in into ack_stat (1 = not acknowledged). Bytes in the receive direction leave ack_stat unchanged.
- R6: ack_time goes to 1 one cycle after the SCL falling strobe with bit_idx=7. It goes back to 0 one cycle after the SCL rising strobe with bit_idx=8.
- R7: cnt_load with cnt_val loads byte_cnt. The SCL falling strobe with bit_idx=8 lowers byte_cnt by one when addr_hit=0. The count holds at 0 and never wraps, and it does not change for a byte with addr_hit=1.
- R8: In host mode (host_mode=1), a stop_req pulse sets stop_pend. Only a stop_done pulse clears it. A stop_req pulse in client mode is ignored.
- R9: In client mode, rx_done together with rx_full sets rx_ovf. The flag stays set until an rx_ovf_clr pulse. rx_done in host mode, or rx_done without rx_full, leaves it at 0.
- R10: In client mode, tx_start together with tx_empty sets tx_unf. The flag stays set until a tx_unf_clr pulse. tx_start in host mode, or tx_start without tx_empty, leaves it at 0.
- R11: In the transmit direction sda_low stays 0 through the whole acknowledge clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_rise | input | 1 | One-cycle strobe on an SCL rising edge |
| scl_fall | input | 1 | One-cycle strobe on an SCL falling edge |
| bit_idx | input | 4 | Bit in progress, 0..7 data, 8 acknowledge |
| dir_tx | input | 1 | 1 = engine transmits the byte, 0 = it receives |
| sda_in | input | 1 | Sampled SDA level |
| addr_hit | input | 1 | Current byte is a matching address |
| ack_data | input | 1 | Acknowledge value while bytes remain (1 = NACK) |
| ack_eoc | input | 1 | Acknowledge value at count zero (1 = NACK) |
| cnt_load | input | 1 | Load pulse for the byte counter |
| cnt_val | input | 8 | Value to load into the byte counter |
| host_mode | input | 1 | 1 = host, 0 = client |
| stop_req | input | 1 | Software write of 1 to the Stop bit |
| stop_done | input | 1 | Pulse: Stop condition has been sent |
| rx_done | input | 1 | Pulse: a byte arrived from the host |
| rx_full | input | 1 | Receive buffer still holds unread data |
| tx_start | input | 1 | Pulse: the host begins reading a byte |
| tx_empty | input | 1 | Transmit buffer is empty |
| rx_ovf_clr | input | 1 | Software clear of rx_ovf |
| tx_unf_clr | input | 1 | Software clear of tx_unf |
| sda_low | output | 1 | Pull SDA low (ACK) |
| ack_time | output | 1 | Bus is inside an acknowledge window |
| ack_stat | output | 1 | Last acknowledge received (1 = NACK) |
| byte_cnt | output | 8 | Remaining-byte count |
| stop_pend | output | 1 | Stop request pending |
| rx_ovf | output | 1 | Sticky client receive overflow |
| tx_unf | output | 1 | Sticky client transmit underflow |

## Verification
The assertions check the cycle timing on every cycle. That covers the set and clear edges of the acknowledge-window flag, the frozen acknowledge level during the drive window, and sda_in landing in ack_stat. It also covers the counter holding at zero and the Stop bit and error flags staying set until their own clear events. Only the bench's scenarios can show that the right one of the two programmable values reaches SDA. The bench sweeps count zero, one and two against address-match and both settings of each value, with the expected level and next count worked out arithmetically. The bench also shows that the mode qualifiers keep the Stop bit and the error flags from reacting in the wrong mode.

// File: rtl/i2c_ack_pkg.sv
// Package: constants shared by the acknowledge controller and its bench.
// Assumes a byte of DATA_BITS data clocks followed by one acknowledge clock.
package i2c_ack_pkg;
    localparam int DATA_BITS = 8;
    localparam int IDX_W     = 4;
    localparam int CNT_W     = 8;
    localparam logic [IDX_W-1:0] LAST_DATA_IDX = IDX_W'(DATA_BITS - 1);
    localparam logic [IDX_W-1:0] ACK_IDX       = IDX_W'(DATA_BITS);
    // Acknowledge level encoding on the wire.
    typedef enum logic { ACK_LVL = 1'b0, NACK_LVL = 1'b1 } ack_lvl_e;
endpackage

// File: rtl/ack_slot.sv
// Module: ack_slot
// Tracks the acknowledge window, registers the outgoing acknowledge level
// and drives it in receive direction, and latches the incoming acknowledge
// in transmit direction. Assumes strobes last one clk cycle and bit_idx is
// stable around each strobe.
module ack_slot
    import i2c_ack_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic [IDX_W-1:0] bit_idx,
    input  logic             dir_tx,
    input  logic             sda_in,
    input  ack_lvl_e         lvl_sel,
    output logic             ack_time,
    output logic             sda_low,
    output logic             ack_stat,
    output logic             slot_end
);
    logic     data_end;
    logic     ack_rise;
    logic     drive_on;
    ack_lvl_e held_lvl;

    assign data_end = scl_fall && (bit_idx == LAST_DATA_IDX);
    assign ack_rise = scl_rise && (bit_idx == ACK_IDX);
    assign slot_end = scl_fall && (bit_idx == ACK_IDX);

    // Acknowledge-window flag: set on last data falling edge, cleared on ack rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n)        ack_time <= 1'b0;
        else if (data_end) ack_time <= 1'b1;
        else if (ack_rise) ack_time <= 1'b0;
    end

    // Drive window and held level: open at last data fall (receive only), close at ack fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drive_on <= 1'b0;
            held_lvl <= NACK_LVL;
        end else if (data_end && !dir_tx) begin
            drive_on <= 1'b1;
            held_lvl <= lvl_sel;
        end else if (slot_end) begin
            drive_on <= 1'b0;
        end
    end

    // Received acknowledge status: sample SDA on the ack rising edge when transmitting.
    always_ff @(posedge clk) begin
        if (!rst_n)                  ack_stat <= 1'b0;
        else if (ack_rise && dir_tx) ack_stat <= sda_in;
    end

    assign sda_low = drive_on && (held_lvl == ACK_LVL);

    p_ack_time_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        data_end |=> ack_time);
    p_ack_time_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_rise && !data_end) |=> !ack_time);
    p_level_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_on && !slot_end && !data_end) |=> $stable(sda_low));
    p_stat_sample_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_rise && dir_tx) |=> (ack_stat == $past(sda_in)));
    p_stat_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(ack_rise && dir_tx) |=> $stable(ack_stat));
endmodule

// File: rtl/byte_countdown.sv
// Module: byte_countdown
// Remaining-byte counter: loadable, decrements once per data byte at the
// end of its acknowledge clock, saturates at zero. Address bytes do not count.
module byte_countdown
    import i2c_ack_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         slot_end,
    input  logic         addr_byte,
    output logic [W-1:0] count,
    output logic         is_zero
);
    assign is_zero = (count == '0);

    // Count register: load wins over decrement; zero holds.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  count <= '0;
        else if (load)                               count <= load_val;
        else if (slot_end && !addr_byte && !is_zero) count <= count - 1'b1;
    end

    p_no_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (is_zero && !load) |=> (count == '0));
    p_addr_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && addr_byte) |=> $stable(count));
endmodule

// File: rtl/sticky_flag.sv
// Module: sticky_flag
// One status bit that hardware sets and a separate event clears.
// Set takes priority over clear in the same cycle.
module sticky_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);
    // Flag register: set-dominant sticky bit.
    always_ff @(posedge clk) begin
        if (!rst_n)   flag <= 1'b0;
        else if (set) flag <= 1'b1;
        else if (clr) flag <= 1'b0;
    end

    p_sticky_hold_r9_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag);
    p_no_spurious_r8_r9_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag && !set) |=> !flag);
endmodule

// File: rtl/i2c_ack_status.sv
// Module: i2c_ack_status (top)
// Acknowledge and status controller for an I2C byte engine. Chooses the
// acknowledge value from the byte count and address match, runs the
// acknowledge slot, the remaining-byte counter, the host Stop bit and the
// client error flags. Assumes a separate shifter provides SCL strobes.
module i2c_ack_status
    import i2c_ack_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic [IDX_W-1:0] bit_idx,
    input  logic             dir_tx,
    input  logic             sda_in,
    input  logic             addr_hit,
    input  logic             ack_data,
    input  logic             ack_eoc,
    input  logic             cnt_load,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             host_mode,
    input  logic             stop_req,
    input  logic             stop_done,
    input  logic             rx_done,
    input  logic             rx_full,
    input  logic             tx_start,
    input  logic             tx_empty,
    input  logic             rx_ovf_clr,
    input  logic             tx_unf_clr,
    output logic             sda_low,
    output logic             ack_time,
    output logic             ack_stat,
    output logic [CNT_W-1:0] byte_cnt,
    output logic             stop_pend,
    output logic             rx_ovf,
    output logic             tx_unf
);
    localparam int NFLAG = 2;

    logic       cnt_zero;
    logic       slot_end;
    ack_lvl_e   lvl_sel;
    logic [NFLAG-1:0] f_set;
    logic [NFLAG-1:0] f_clr;
    logic [NFLAG-1:0] f_out;

    // Acknowledge value select: end-of-count value only at zero on a data byte.
    always_comb begin
        if (cnt_zero && !addr_hit) lvl_sel = ack_eoc  ? NACK_LVL : ACK_LVL;
        else                       lvl_sel = ack_data ? NACK_LVL : ACK_LVL;
    end

    ack_slot u_slot (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .bit_idx  (bit_idx),
        .dir_tx   (dir_tx),
        .sda_in   (sda_in),
        .lvl_sel  (lvl_sel),
        .ack_time (ack_time),
        .sda_low  (sda_low),
        .ack_stat (ack_stat),
        .slot_end (slot_end)
    );

    byte_countdown #(.W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (cnt_load),
        .load_val  (cnt_val),
        .slot_end  (slot_end),
        .addr_byte (addr_hit),
        .count     (byte_cnt),
        .is_zero   (cnt_zero)
    );

    // Flag event map: index 0 = receive overflow, 1 = transmit underflow (client only).
    assign f_set[0] = !host_mode && rx_done  && rx_full;
    assign f_clr[0] = rx_ovf_clr;
    assign f_set[1] = !host_mode && tx_start && tx_empty;
    assign f_clr[1] = tx_unf_clr;

    for (genvar g = 0; g < NFLAG; g++) begin : g_flag
        sticky_flag u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .set   (f_set[g]),
            .clr   (f_clr[g]),
            .flag  (f_out[g])
        );
    end

    assign rx_ovf = f_out[0];
    assign tx_unf = f_out[1];

    // Host Stop bit: software sets in host mode, only completion clears.
    always_ff @(posedge clk) begin
        if (!rst_n)                       stop_pend <= 1'b0;
        else if (stop_pend && stop_done)  stop_pend <= 1'b0;
        else if (stop_req && host_mode)   stop_pend <= 1'b1;
    end

    p_stop_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_pend && !stop_done) |=> stop_pend);
    p_stop_client_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!stop_pend && !host_mode) |=> !stop_pend);
    p_tx_no_drive_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_tx && !sda_low && !(scl_fall && bit_idx == LAST_DATA_IDX)) |=> !sda_low);
endmodule

// File: tb/i2c_ack_status_tb.sv
module i2c_ack_status_tb;
    import i2c_ack_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_rise = 0, scl_fall = 0, dir_tx = 0, sda_in = 1, addr_hit = 0;
    logic ack_data = 0, ack_eoc = 0, cnt_load = 0, host_mode = 0;
    logic [IDX_W-1:0] bit_idx = '0;
    logic [CNT_W-1:0] cnt_val = '0;
    logic stop_req = 0, stop_done = 0, rx_done = 0, rx_full = 0;
    logic tx_start = 0, tx_empty = 0, rx_ovf_clr = 0, tx_unf_clr = 0;
    logic sda_low, ack_time, ack_stat, stop_pend, rx_ovf, tx_unf;
    logic [CNT_W-1:0] byte_cnt;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    i2c_ack_status u_dut (.*);

    task automatic chk(input string req, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s got=%0d exp=%0d", req, got, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_rise();
        scl_rise = 1; tick(); scl_rise = 0; tick();
    endtask

    task automatic pulse_fall();
        scl_fall = 1; tick(); scl_fall = 0;
    endtask

    task automatic load_cnt(input int v);
        cnt_val = CNT_W'(v); cnt_load = 1; tick(); cnt_load = 0;
    endtask

    // One byte; checks window timing and the driven level against exp_low.
    task automatic run_byte(input bit tx, input bit ahit, input bit rx_ack, input bit exp_low);
        dir_tx = tx; addr_hit = ahit;
        for (int b = 0; b < DATA_BITS; b++) begin
            bit_idx = IDX_W'(b);
            pulse_rise();
            if (b == DATA_BITS - 1) begin
                chk("R6 no window before last fall", ack_time, 0);
                chk("R4 no drive before last fall", sda_low, 0);
            end
            pulse_fall();
            tick();
        end
        chk("R6 window set after last data fall", ack_time, 1);
        chk(tx ? "R11 no drive in tx" : "R2/R3 ack level", sda_low, tx ? 0 : exp_low);
        ack_data = ~ack_data; ack_eoc = ~ack_eoc;
        tick();
        chk("R4 level held after cfg change", sda_low, tx ? 0 : exp_low);
        bit_idx = ACK_IDX; sda_in = rx_ack;
        scl_rise = 1; tick(); scl_rise = 0;
        chk("R6 window cleared after ack rise", ack_time, 0);
        chk(tx ? "R11 no drive in ack high" : "R4 drive through ack high", sda_low, tx ? 0 : exp_low);
        tick();
        pulse_fall();
        chk("R4 drive released after ack fall", sda_low, 0);
        ack_data = ~ack_data; ack_eoc = ~ack_eoc;
        sda_in = 1; bit_idx = '0; tick();
    endtask

    initial begin
        #(8 * 200000);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        tick(3);
        chk("R1 sda_low", sda_low, 0); chk("R1 ack_time", ack_time, 0);
        chk("R1 ack_stat", ack_stat, 0); chk("R1 byte_cnt", byte_cnt, 0);
        chk("R1 stop_pend", stop_pend, 0); chk("R1 rx_ovf", rx_ovf, 0);
        chk("R1 tx_unf", tx_unf, 0);
        rst_n = 1; tick();

        // R2/R3/R7 sweep over count, address match and both programmed values.
        for (int c = 0; c < 3; c++)
            for (int a = 0; a < 2; a++)
                for (int e = 0; e < 2; e++)
                    for (int d = 0; d < 2; d++) begin
                        int lvl;
                        int nxt;
                        load_cnt(c);
                        chk("R7 load", byte_cnt, c);
                        ack_eoc = e[0]; ack_data = d[0];
                        lvl = (c == 0 && a == 0) ? e : d;
                        run_byte(1'b0, a[0], 1'b1, lvl == 0);
                        nxt = (a == 1) ? c : ((c == 0) ? 0 : c - 1);
                        chk("R7 count after byte", byte_cnt, nxt);
                    end

        // R7 countdown across several data bytes, saturating at zero.
        load_cnt(2); ack_data = 0; ack_eoc = 1;
        run_byte(1'b0, 1'b0, 1'b1, 1'b1);
        chk("R7 2->1", byte_cnt, 1);
        run_byte(1'b0, 1'b0, 1'b1, 1'b1);
        chk("R7 1->0", byte_cnt, 0);
        run_byte(1'b0, 1'b0, 1'b1, 1'b0);
        chk("R7 hold at 0", byte_cnt, 0);

        // R5 / R11: transmit bytes capture the receiver's answer.
        run_byte(1'b1, 1'b0, 1'b1, 1'b0);
        chk("R5 NACK captured", ack_stat, 1);
        run_byte(1'b1, 1'b0, 1'b0, 1'b0);
        chk("R5 ACK captured", ack_stat, 0);
        ack_data = 1; load_cnt(1);
        run_byte(1'b0, 1'b0, 1'b1, 1'b0);
        chk("R5 rx byte leaves status", ack_stat, 0);
        addr_hit = 0;

        // R8: host Stop bit.
        host_mode = 1; stop_req = 1; tick(); stop_req = 0;
        chk("R8 stop set", stop_pend, 1);
        tick(4);
        chk("R8 stop held", stop_pend, 1);
        stop_done = 1; tick(); stop_done = 0;
        chk("R8 stop cleared by done", stop_pend, 0);
        host_mode = 0; stop_req = 1; tick(); stop_req = 0;
        chk("R8 client request ignored", stop_pend, 0);

        // R9: receive overflow.
        host_mode = 1; rx_done = 1; rx_full = 1; tick(); rx_done = 0;
        chk("R9 host mode no flag", rx_ovf, 0);
        host_mode = 0; rx_full = 0; rx_done = 1; tick(); rx_done = 0;
        chk("R9 buffer not full no flag", rx_ovf, 0);
        rx_full = 1; rx_done = 1; tick(); rx_done = 0; rx_full = 0;
        chk("R9 set", rx_ovf, 1);
        tick(5);
        chk("R9 sticky", rx_ovf, 1);
        rx_ovf_clr = 1; tick(); rx_ovf_clr = 0;
        chk("R9 cleared", rx_ovf, 0);

        // R10: transmit underflow.
        host_mode = 1; tx_start = 1; tx_empty = 1; tick(); tx_start = 0;
        chk("R10 host mode no flag", tx_unf, 0);
        host_mode = 0; tx_empty = 0; tx_start = 1; tick(); tx_start = 0;
        chk("R10 buffer not empty no flag", tx_unf, 0);
        tx_empty = 1; tx_start = 1; tick(); tx_start = 0; tx_empty = 0;
        chk("R10 set", tx_unf, 1);
        tick(5);
        chk("R10 sticky", tx_unf, 1);
        tx_unf_clr = 1; tick(); tx_unf_clr = 0;
        chk("R10 cleared", tx_unf, 0);

        // R1: reset returns everything to zero.
        load_cnt(5); stop_req = 1; host_mode = 1; tick(); stop_req = 0;
        rst_n = 0; tick(); rst_n = 1;
        chk("R1 count after reset", byte_cnt, 0);
        chk("R1 stop after reset", stop_pend, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule